// File: doc/BRIEF.md
# PHY power-up sequencer

This block takes a serial display PHY from full reset to a confirmed running state in a fixed order. After an enable request it raises the PHY clock enable on its own. It then also releases shutdown, and finally releases reset. Each step is held for a minimum time measured in microseconds, and the microsecond is derived from the block clock by a divider parameter. After the final release, a settle interval runs. The block then samples the PHY status once per microsecond until the PLL-lock bit or the clock-lane stop-state bit is set, or until the allowed number of attempts is used up.

On success the block reports ready and raises core power-up and the high-speed clock request. On failure it reports timeout and keeps the PHY controls where they are. A disable request ends any state at once and drops every control output to zero. The block also captures a PHY interface configuration word when it accepts an enable. The low field of that word holds the lane count minus one, and the stop-wait time starts at bit 8.

All pins are plain level control and status; no data stream passes through the block. Timing in the requirements uses DIV = `CLK_PER_US`, S = `STEP_US`, L = `SETTLE_US` and N = `POLL_LIMIT`. Cycle 0 is the first clock cycle after the edge that accepts the enable.

Top module: `dphy_pwr_seq`

## Requirements
- R1: During and right after reset, every control and status output is 0 and `if_cfg` is all zeros.
- R2: The PHY control triple {`phy_enableclk`, `phy_shutdown_n`, `phy_rst_n`} only takes the values 000, 100, 110 and 111. Each stage is entered only from the one before it or from 000, and an accepted enable moves to 100 on the next cycle.
- R3: The clock-enable-only stage and the clock-enable-plus-unshutdown stage each last S*DIV+1 cycles. The all-released stage then lasts L*DIV+1 cycles before polling starts.
- R4: Polling attempt k falls on the k-th microsecond tick of the poll phase. An attempt succeeds when synchronised status bit 0 or bit 2 is 1, and status bit 1 has no effect. After success at attempt k, `ready` is first seen at cycle 2*(S*DIV+1)+L*DIV+1+k*DIV.
- R5: If N attempts all fail, `timeout` rises N*DIV cycles after polling begins. `ready` and `timeout` are never both 1, and each stays 1 until a disable.
- R6: `core_pwr_up` and `lpclk_hs_req` are 1 exactly while `ready` is 1.
- R7: A disable in any state brings every control and status output to 0 on the next cycle and returns the block to idle. A disable overrides an enable given in the same cycle.
- R8: An enable given in any state other than idle, including ready and timeout, changes neither the outputs, the sequence timing nor `if_cfg`.
- R9: On an accepted enable, `if_cfg` takes `lane_num`-1 in bits [2:0] and `stop_wait` in bits [15:8], with the other bits 0. It keeps that value until the next accepted enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Start the power-up sequence (taken only in idle) |
| dis_req | input | 1 | Power down and return to idle |
| lane_num | input | LANE_FW (3) | Number of data lanes, 1 to 4 |
| stop_wait | input | STOPW_W (8) | Stop-state wait time for the configuration word |
| phy_stat | input | 3 | PHY status: bit 0 PLL lock, bit 2 clock-lane stop state |
| phy_enableclk | output | 1 | PHY clock enable |
| phy_shutdown_n | output | 1 | PHY shutdown release (active high) |
| phy_rst_n | output | 1 | PHY reset release (active high) |
| core_pwr_up | output | 1 | Core power-up |
| lpclk_hs_req | output | 1 | High-speed clock-lane request |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | PHY confirmed ready |
| timeout | output | 1 | Polling gave up |
| if_cfg | output | CFG_W (16) | Captured PHY interface configuration word |

## Verification
The hardest case to reach from the ports is a status bit that turns on partway through polling, after some attempts have already failed. Once it reaches the synchroniser, it must be seen at exactly the next attempt. The bench times the enable itself and counts cycles from the accepting edge. It raises the status one microsecond before a chosen attempt k, with k picked at random up to the last permitted attempt. A bench function then gives the exact cycle of `ready`, so a change that moves the attempt grid or the synchroniser depth shows up as a wrong count.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLKEN  = 3'd1,
    ST_UNSHUT = 3'd2,
    ST_SETTLE = 3'd3,
    ST_POLL   = 3'd4,
    ST_READY  = 3'd5,
    ST_TMO    = 3'd6
  } dps_state_e;

  typedef struct packed {
    logic enclk;
    logic shut_n;
    logic rst_n;
    logic pwr;
    logic busy;
    logic rdy;
    logic tmo;
  } dps_drive_t;

  function automatic dps_drive_t dps_decode(dps_state_e s);
    dps_drive_t d;
    d        = '0;
    d.enclk  = (s != ST_IDLE);
    d.shut_n = (s != ST_IDLE) && (s != ST_CLKEN);
    d.rst_n  = (s == ST_SETTLE) || (s == ST_POLL) ||
               (s == ST_READY)  || (s == ST_TMO);
    d.pwr    = (s == ST_READY);
    d.busy   = (s == ST_CLKEN) || (s == ST_UNSHUT) ||
               (s == ST_SETTLE) || (s == ST_POLL);
    d.rdy    = (s == ST_READY);
    d.tmo    = (s == ST_TMO);
    return d;
  endfunction

  function automatic int dps_max3(int a, int b, int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/dps_us_tick.sv
module dps_us_tick #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dps_us_wait.sv
module dps_us_wait #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] target,
  output logic [W-1:0] count,
  output logic         done
);
  assign done = (count == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (tick && !done) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/dps_stat_sync.sv
module dps_stat_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stg[i] <= '0;
          end else if (i == 0) begin
            stg[i] <= d;
          end else begin
            stg[i] <= stg[(i > 0) ? i - 1 : 0];
          end
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dphy_pwr_seq.sv
module dphy_pwr_seq
  import dps_pkg::*;
#(
  parameter int CLK_PER_US  = 20,
  parameter int STEP_US     = 1,
  parameter int SETTLE_US   = 1000,
  parameter int POLL_LIMIT  = 100,
  parameter int SYNC_STAGES = 2,
  parameter int LANE_FW     = 3,
  parameter int STOPW_W     = 8,
  parameter int STOPW_LSB   = 8,
  parameter int CFG_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_req,
  input  logic               dis_req,
  input  logic [LANE_FW-1:0] lane_num,
  input  logic [STOPW_W-1:0] stop_wait,
  input  logic [2:0]         phy_stat,
  output logic               phy_enableclk,
  output logic               phy_shutdown_n,
  output logic               phy_rst_n,
  output logic               core_pwr_up,
  output logic               lpclk_hs_req,
  output logic               busy,
  output logic               ready,
  output logic               timeout,
  output logic [CFG_W-1:0]   if_cfg
);
  localparam int MAXW = dps_max3(STEP_US, SETTLE_US, POLL_LIMIT);
  localparam int UW   = $clog2(MAXW + 1);
  localparam logic [UW-1:0] T_STEP   = UW'(STEP_US);
  localparam logic [UW-1:0] T_SETTLE = UW'(SETTLE_US);
  localparam logic [UW-1:0] T_POLL   = UW'(POLL_LIMIT - 1);
  localparam logic [2:0]    OK_MASK  = 3'b101;

  dps_state_e           state, nxt;
  dps_drive_t           drv;
  logic                 us_tick, w_clr, w_done, stat_ok, accept;
  logic [UW-1:0]        w_target, w_cnt;
  logic [2:0]           stat_s;
  logic [LANE_FW-1:0]   lane_m1;
  logic [CFG_W-1:0]     cfg_nxt;

  dps_stat_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(phy_stat), .q(stat_s)
  );

  dps_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(w_clr), .tick(us_tick)
  );

  dps_us_wait #(.W(UW)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(w_clr), .tick(us_tick),
    .target(w_target), .count(w_cnt), .done(w_done)
  );

  assign stat_ok = |(stat_s & OK_MASK);
  assign accept  = (state == ST_IDLE) && en_req && !dis_req;

  always_comb begin
    unique case (state)
      ST_CLKEN, ST_UNSHUT: w_target = T_STEP;
      ST_SETTLE:           w_target = T_SETTLE;
      default:             w_target = T_POLL;
    endcase
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (en_req) nxt = ST_CLKEN;
      ST_CLKEN:  if (w_done) nxt = ST_UNSHUT;
      ST_UNSHUT: if (w_done) nxt = ST_SETTLE;
      ST_SETTLE: if (w_done) nxt = ST_POLL;
      ST_POLL: begin
        if (us_tick) begin
          if (stat_ok)              nxt = ST_READY;
          else if (w_cnt == T_POLL) nxt = ST_TMO;
        end
      end
      default:   nxt = state;
    endcase
    if (dis_req) nxt = ST_IDLE;
  end

  assign w_clr = (nxt != state) || (state == ST_IDLE);

  always_comb begin
    lane_m1 = lane_num - LANE_FW'(1);
    cfg_nxt = '0;
    cfg_nxt[LANE_FW-1:0]          = lane_m1;
    cfg_nxt[STOPW_LSB +: STOPW_W] = stop_wait;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      drv    <= '0;
      if_cfg <= '0;
    end else begin
      state <= nxt;
      drv   <= dps_decode(nxt);
      if (accept) if_cfg <= cfg_nxt;
    end
  end

  assign phy_enableclk  = drv.enclk;
  assign phy_shutdown_n = drv.shut_n;
  assign phy_rst_n      = drv.rst_n;
  assign core_pwr_up    = drv.pwr;
  assign lpclk_hs_req   = drv.pwr;
  assign busy           = drv.busy;
  assign ready          = drv.rdy;
  assign timeout        = drv.tmo;
endmodule

// File: rtl/dps_pwr_seq_chk.sv
module dps_pwr_seq_chk #(
  parameter int CLK_PER_US = 20,
  parameter int STEP_US    = 1,
  parameter int CFG_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_req,
  input logic             dis_req,
  input logic             phy_enableclk,
  input logic             phy_shutdown_n,
  input logic             phy_rst_n,
  input logic             core_pwr_up,
  input logic             lpclk_hs_req,
  input logic             busy,
  input logic             ready,
  input logic             timeout,
  input logic [CFG_W-1:0] if_cfg
);
  localparam logic [31:0] MIN_STEP = 32'(STEP_US * CLK_PER_US + 1);

  logic [31:0] ph_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_cnt <= '0;
    else if (phy_enableclk && !phy_shutdown_n) ph_cnt <= ph_cnt + 1'b1;
    else ph_cnt <= '0;
  end

  AST_SHUT_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    phy_shutdown_n |-> phy_enableclk); // R2
  AST_RST_NEEDS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst_n |-> phy_shutdown_n); // R2
  AST_RST_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> $past(phy_shutdown_n)); // R2
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !dis_req && !phy_enableclk) |=> (phy_enableclk && !phy_shutdown_n)); // R2
  AST_STEP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_shutdown_n) |-> (ph_cnt >= MIN_STEP)); // R3
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout)); // R5
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !dis_req) |=> ready); // R5
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !dis_req) |=> timeout); // R5
  AST_PWR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_up == ready) && (lpclk_hs_req == ready)); // R6
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> !(phy_enableclk || phy_shutdown_n || phy_rst_n || core_pwr_up ||
                  lpclk_hs_req || busy || ready || timeout)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy || ready || timeout) && !dis_req) |=> $stable(if_cfg)); // R8
endmodule

bind dphy_pwr_seq dps_pwr_seq_chk #(
  .CLK_PER_US(CLK_PER_US), .STEP_US(STEP_US), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
  .phy_enableclk(phy_enableclk), .phy_shutdown_n(phy_shutdown_n),
  .phy_rst_n(phy_rst_n), .core_pwr_up(core_pwr_up),
  .lpclk_hs_req(lpclk_hs_req), .busy(busy), .ready(ready),
  .timeout(timeout), .if_cfg(if_cfg)
);

// File: tb/sim_dphy_pwr_seq.sv
`timescale 1ns/1ps
module sim_dphy_pwr_seq;
  localparam int DIV = 4;
  localparam int S   = 1;
  localparam int L   = 6;
  localparam int LIM = 5;
  localparam int SY  = 2;
  localparam int P0  = 2 * (S * DIV + 1) + L * DIV + 1;

  logic        clk = 1'b0;
  logic        rst_n, en_req, dis_req;
  logic [2:0]  lane_num;
  logic [7:0]  stop_wait;
  logic [2:0]  phy_stat;
  logic        phy_enableclk, phy_shutdown_n, phy_rst_n, core_pwr_up, lpclk_hs_req;
  logic        busy, ready, timeout;
  logic [15:0] if_cfg;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dphy_pwr_seq #(
    .CLK_PER_US(DIV), .STEP_US(S), .SETTLE_US(L), .POLL_LIMIT(LIM),
    .SYNC_STAGES(SY), .LANE_FW(3), .STOPW_W(8), .STOPW_LSB(8), .CFG_W(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .lane_num(lane_num), .stop_wait(stop_wait), .phy_stat(phy_stat),
    .phy_enableclk(phy_enableclk), .phy_shutdown_n(phy_shutdown_n),
    .phy_rst_n(phy_rst_n), .core_pwr_up(core_pwr_up), .lpclk_hs_req(lpclk_hs_req),
    .busy(busy), .ready(ready), .timeout(timeout), .if_cfg(if_cfg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cfg(input int ln, input int sw);
    return ((sw & 255) << 8) | ((ln - 1) & 7);
  endfunction

  function automatic int outs();
    return int'({phy_enableclk, phy_shutdown_n, phy_rst_n, core_pwr_up,
                 lpclk_hs_req, busy, ready, timeout});
  endfunction

  task automatic settle_stat(input logic [2:0] v);
    phy_stat = v;
    repeat (SY + 2) @(negedge clk);
  endtask

  task automatic run_seq(input logic [2:0] st0, input int j_arr, input logic [2:0] st_arr,
                         input bit exp_rdy, input int exp_att, input bit mid_en,
                         input int ln, input int sw);
    int cyc, c1, c2, c3, bad;
    cyc = 0; c1 = 0; c2 = 0; c3 = 0; bad = 0;
    settle_stat(st0);
    lane_num  = 3'(ln);
    stop_wait = 8'(sw);
    en_req    = 1'b1;
    @(negedge clk);
    en_req    = 1'b0;
    lane_num  = 3'(($urandom % 4) + 1);
    stop_wait = 8'($urandom);
    while (!(ready || timeout) && cyc < P0 + LIM * DIV + 20) begin
      if (j_arr > 0 && cyc == P0 + (j_arr - 1) * DIV) phy_stat = st_arr;
      en_req = (mid_en && cyc == 3);
      case ({phy_enableclk, phy_shutdown_n, phy_rst_n})
        3'b100:  c1++;
        3'b110:  c2++;
        3'b111:  c3++;
        default: bad++;
      endcase
      cyc++;
      @(negedge clk);
    end
    en_req = 1'b0;
    chk("R2 illegal control pattern cycles", bad, 0);
    chk("R3 clock-enable-only cycles", c1, S * DIV + 1);
    chk("R3 unshutdown stage cycles", c2, S * DIV + 1);
    chk("R3 settle plus poll cycles", c3, L * DIV + 1 + exp_att * DIV);
    chk(exp_rdy ? "R4 cycles to ready" : "R5 cycles to timeout", cyc, P0 + exp_att * DIV);
    chk("R4 ready level", int'(ready), int'(exp_rdy));
    chk("R5 timeout level", int'(timeout), int'(!exp_rdy));
    chk("R6 core power level", int'(core_pwr_up), int'(exp_rdy));
    chk("R6 clock request level", int'(lpclk_hs_req), int'(exp_rdy));
    chk("R9 captured config word", int'(if_cfg), exp_cfg(ln, sw));
    if (mid_en) chk("R8 busy enable left timing alone", cyc, P0 + exp_att * DIV);
  endtask

  task automatic post_hold(input bit exp_rdy);
    int cfg0, o0;
    repeat (5) @(negedge clk);
    chk("R5 result held", int'(ready ? 1 : (timeout ? 2 : 0)), exp_rdy ? 1 : 2);
    cfg0 = int'(if_cfg);
    o0 = outs();
    lane_num  = 3'd2;
    stop_wait = 8'h5A;
    en_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0;
    @(negedge clk);
    chk("R8 enable ignored, outputs", outs(), o0);
    chk("R8 enable ignored, config word", int'(if_cfg), cfg0);
  endtask

  task automatic do_dis(input string tag);
    dis_req = 1'b1;
    @(negedge clk);
    dis_req = 1'b0;
    chk(tag, outs(), 0);
  endtask

  task automatic dis_mid(input int k);
    settle_stat(3'b000);
    lane_num = 3'd3; stop_wait = 8'h11;
    en_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0;
    repeat (k) @(negedge clk);
    do_dis("R7 disable mid-sequence");
    repeat (3) @(negedge clk);
    chk("R7 stays idle after disable", outs(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1..R9 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; en_req = 1'b0; dis_req = 1'b0;
    lane_num = 3'd1; stop_wait = 8'd0; phy_stat = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", outs(), 0);
    chk("R1 config word in reset", int'(if_cfg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", outs(), 0);

    run_seq(3'b001, 0, 3'b000, 1'b1, 1, 1'b0, 4, 8'h2A);   // R4 bit 0
    post_hold(1'b1);
    do_dis("R7 disable from ready");

    run_seq(3'b100, 0, 3'b000, 1'b1, 1, 1'b1, 1, 8'hC3);   // R4 bit 2, R8 busy enable
    do_dis("R7 disable from ready");

    run_seq(3'b010, 0, 3'b000, 1'b0, LIM, 1'b0, 2, 8'h07); // R4 bit 1 ignored, R5
    post_hold(1'b0);
    do_dis("R7 disable from timeout");

    run_seq(3'b000, LIM, 3'b101, 1'b1, LIM, 1'b0, 3, 8'hFF); // R4 last attempt
    do_dis("R7 disable from ready");

    dis_mid(0);
    dis_mid(S * DIV + 2);
    dis_mid(P0 + 2);

    en_req = 1'b1; dis_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0; dis_req = 1'b0;
    @(negedge clk);
    chk("R7 disable beats enable", outs(), 0);

    for (int it = 0; it < 14; it++) begin
      int mode, ln, sw, j;
      logic [2:0] v, z;
      mode = int'($urandom % 4);
      ln = int'($urandom % 4) + 1;
      sw = int'($urandom % 256);
      v = 3'($urandom % 8);
      if ((v & 3'b101) == 3'b000) v = v | 3'b001;
      z = ($urandom % 2) ? 3'b010 : 3'b000;
      case (mode)
        0: begin run_seq(v, 0, 3'b000, 1'b1, 1, 1'b0, ln, sw); do_dis("R7 random disable"); end
        1: begin run_seq(z, 0, 3'b000, 1'b0, LIM, 1'b0, ln, sw); do_dis("R7 random disable"); end
        2: begin
             j = int'($urandom % (LIM - 1)) + 2;
             run_seq(z, j, v, 1'b1, j, 1'b0, ln, sw);
             do_dis("R7 random disable");
           end
        default: dis_mid(int'($urandom % (P0 + 8)));
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule